// File: doc/BRIEF.md
# Register-Driven Half-Duplex Serial Flash Master

This block is a serial peripheral master that software drives through three 32-bit registers. It is meant for a boot NOR flash. Each transaction moves one byte or one 4-byte word, and data goes in one direction only. Writing the data register sends the written value. Reading the data register returns the last received word and starts the next receive. Both chip-select pins follow register bits directly, so software frames a flash command as it likes. A ready flag in the control register tells software when it may start the next access.

The serial clock uses mode 0: it idles low, data is sampled on the rising edge and changed after the falling edge, and each byte goes out MSB first. The serial clock runs at the system clock divided by the parameter `DIV`, which must be even. Two configuration bits set the byte order of 4-byte transfers, one for each direction. A single byte always sits in bits 31:24 of the data word.

The register bus is a single-cycle strobe. An access happens on every clock edge where `bus_sel` is high. Read data is combinational while the strobe is high.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset, `spi_cs_n` is 2'b11 and `spi_sclk` is low. The control register (offset 0x08) reads 0xC800_0000, which means both chip-select bits are high, the length is 0, ready is 1 and select is 0. The configuration register (offset 0x00) reads 0.
- R2: While the block is idle, `spi_cs_n[0]` follows control bit 31 and `spi_cs_n[1]` follows control bit 30, from the clock edge that accepts the write.
- R3: A write to the data register (offset 0x0C) while idle sends the programmed length, MSB first. Length code 3 (control bits 29:28) sends 4 bytes. Any other code sends 1 byte, taken from data bits 31:24. Each byte takes exactly 8 rising clock edges.
- R4: In a 4-byte transmit with configuration bit 27 set, bits 31:24 go out first and bits 7:0 go out last. With bit 27 clear, bits 7:0 go out first and bits 31:24 go out last.
- R5: Ready (control bit 27) reads 0 from the cycle after the access that starts a transfer. It stays 0 for exactly 8*DIV cycles per byte moved, then reads 1.
- R6: A 1-byte receive puts the received byte in data bits 31:24, with bits 23:0 zero.
- R7: In a 4-byte receive with configuration bit 28 set, the first byte received lands in bits 31:24. With bit 28 clear, the first byte received lands in bits 7:0.
- R8: A data-register read while idle returns the word captured by the most recent receive and starts a new receive of the programmed length. During any receive, `spi_mosi` is held at 0.
- R9: When a control write, made while idle, takes the chip select picked by bit 24 from high to low, a receive starts on its own. Bit 24 = 0 picks chip select 0 and bit 24 = 1 picks chip select 1.
- R10: Writes to the control or data register while ready is 0 have no effect. Chip-select levels, length, select and the transfer in flight all stay unchanged.
- R11: While a transfer runs, the rising edges of `spi_sclk` come DIV system cycles apart. `spi_mosi` never changes on a rising edge, and `spi_sclk` is low whenever the block is idle.
- R12: A transmit does not change the word that the next data-register read returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 2 | Active-low chip selects, bit 0 = select 0 |

## Verification
The hardest case to reach is the chain of receives. Each data read returns the result of the previous receive, so the value checked at any read was set up one transfer earlier, by the flash model's stream and by the order bit in force when that receive started. The stimulus first starts a receive by taking the selected chip select low. It then alternates reads with changes to the length and the receive order bit, and puts a transmit between two receives, so each returned word shows whether the right earlier transfer filled it. A separate sequence issues control and data writes while a byte is still moving, to show that these writes are dropped.

// File: rtl/spi_fl_pkg.sv
package spi_fl_pkg;
  localparam int OFF_CFG = 'h00;
  localparam int OFF_CTL = 'h08;
  localparam int OFF_DAT = 'h0C;

  // control register field positions
  localparam int B_CS0   = 31;
  localparam int B_CS1   = 30;
  localparam int B_LENHI = 29;
  localparam int B_LENLO = 28;
  localparam int B_RDY   = 27;
  localparam int B_SEL   = 24;
  // configuration register field positions
  localparam int B_RXBE  = 28;
  localparam int B_TXBE  = 27;

  localparam logic [1:0] LEN_WORD = 2'd3;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // word placed in the shift register, first serial bit at [31]
  function automatic logic [31:0] tx_load(input logic [31:0] w, input logic four,
                                          input logic be);
    if (!four) return {w[31:24], 24'h0};
    return be ? w : bswap32(w);
  endfunction

  // word presented to software from the received stream (first bit oldest)
  function automatic logic [31:0] rx_pack(input logic [31:0] sr, input logic four,
                                          input logic be);
    if (!four) return {sr[7:0], 24'h0};
    return be ? sr : bswap32(sr);
  endfunction

  function automatic logic [5:0] xfer_bits(input logic four);
    return four ? 6'd32 : 6'd8;
  endfunction
endpackage

// File: rtl/spi_fl_regs.sv
module spi_fl_regs
  import spi_fl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          busy,
  input  logic [31:0]   rx_word,
  output logic [31:0]   rdata,
  output logic          start_tx,
  output logic          start_rx,
  output logic          four,
  output logic          tx_be,
  output logic          rx_be,
  output logic [1:0]    cs_n
);
  logic       rx_be_q, tx_be_q, sel_q;
  logic [1:0] cs_lvl;   // [0] = select 0 level
  logic [1:0] len_q;

  logic hit_cfg, hit_ctl, hit_dat, ctl_take, auto_rx;
  logic new_sel, old_lvl, new_lvl;
  logic [1:0] len_eff;

  assign hit_cfg = sel && (addr == AW'(OFF_CFG));
  assign hit_ctl = sel && (addr == AW'(OFF_CTL));
  assign hit_dat = sel && (addr == AW'(OFF_DAT));
  assign ctl_take = hit_ctl && wr && !busy;

  assign new_sel = wdata[B_SEL];
  assign old_lvl = cs_lvl[new_sel];
  assign new_lvl = new_sel ? wdata[B_CS1] : wdata[B_CS0];
  assign auto_rx = ctl_take && old_lvl && !new_lvl;

  assign len_eff  = ctl_take ? wdata[B_LENHI:B_LENLO] : len_q;
  assign four     = (len_eff == LEN_WORD);
  assign start_tx = hit_dat && wr && !busy;
  assign start_rx = (hit_dat && !wr && !busy) || auto_rx;
  assign tx_be    = tx_be_q;
  assign rx_be    = rx_be_q;
  assign cs_n     = cs_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_be_q <= 1'b0;
      tx_be_q <= 1'b0;
      sel_q   <= 1'b0;
      cs_lvl  <= 2'b11;
      len_q   <= 2'd0;
    end else begin
      if (hit_cfg && wr) begin
        rx_be_q <= wdata[B_RXBE];
        tx_be_q <= wdata[B_TXBE];
      end
      if (ctl_take) begin
        cs_lvl <= {wdata[B_CS1], wdata[B_CS0]};
        len_q  <= wdata[B_LENHI:B_LENLO];
        sel_q  <= wdata[B_SEL];
      end
    end
  end

  always_comb begin
    rdata = 32'h0;
    if (hit_cfg) begin
      rdata[B_RXBE] = rx_be_q;
      rdata[B_TXBE] = tx_be_q;
    end else if (hit_ctl) begin
      rdata[B_CS0]           = cs_lvl[0];
      rdata[B_CS1]           = cs_lvl[1];
      rdata[B_LENHI:B_LENLO] = len_q;
      rdata[B_RDY]           = !busy;
      rdata[B_SEL]           = sel_q;
    end else if (hit_dat) begin
      rdata = rx_word;
    end
  end
endmodule

// File: rtl/spi_fl_shift.sv
module spi_fl_shift
  import spi_fl_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_tx,
  input  logic        start_rx,
  input  logic        four,
  input  logic        tx_be,
  input  logic        rx_be,
  input  logic [31:0] tx_word,
  input  logic        miso,
  output logic        start,
  output logic        busy,
  output logic        done,
  output logic        xfer_four,
  output logic        rx_mode,
  output logic        sclk,
  output logic        mosi,
  output logic [31:0] rx_word
);
  localparam int HALF = (DIV < 2) ? 1 : DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          busy_q, sclk_q, four_q, rxm_q, rxbe_q;
  logic [CW-1:0] div_q;
  logic [5:0]    bits_q;
  logic [31:0]   tx_sr, rx_sr, rx_q;
  logic          tick;

  assign tick      = (div_q == CW'(HALF - 1));
  assign start     = (start_tx || start_rx) && !busy_q;
  assign done      = busy_q && tick && sclk_q && (bits_q == 6'd1);
  assign busy      = busy_q;
  assign sclk      = sclk_q;
  assign mosi      = tx_sr[31];
  assign xfer_four = four_q;
  assign rx_mode   = rxm_q;
  assign rx_word   = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      four_q <= 1'b0;
      rxm_q  <= 1'b0;
      rxbe_q <= 1'b0;
      div_q  <= '0;
      bits_q <= '0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      rx_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      div_q  <= '0;
      four_q <= four;
      rxm_q  <= start_rx;
      rxbe_q <= rx_be;
      bits_q <= xfer_bits(four);
      tx_sr  <= start_rx ? 32'h0 : tx_load(tx_word, four, tx_be);
      rx_sr  <= '0;
    end else if (busy_q) begin
      if (tick) begin
        div_q  <= '0;
        sclk_q <= !sclk_q;
        if (!sclk_q) begin
          rx_sr <= {rx_sr[30:0], miso};
        end else begin
          tx_sr  <= {tx_sr[30:0], 1'b0};
          bits_q <= bits_q - 6'd1;
          if (bits_q == 6'd1) begin
            busy_q <= 1'b0;
            if (rxm_q) rx_q <= rx_pack(rx_sr, four_q, rxbe_q);
          end
        end
      end else begin
        div_q <= div_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl #(
  parameter int AW  = 4,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic [1:0]    spi_cs_n
);
  // named internal events, observed by the bound checker
  logic        eng_start, eng_busy, eng_done, eng_four, eng_rxmode;
  logic        req_tx, req_rx, req_four, cfg_tx_be, cfg_rx_be;
  logic [31:0] rx_word;

  spi_fl_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .busy     (eng_busy),
    .rx_word  (rx_word),
    .rdata    (bus_rdata),
    .start_tx (req_tx),
    .start_rx (req_rx),
    .four     (req_four),
    .tx_be    (cfg_tx_be),
    .rx_be    (cfg_rx_be),
    .cs_n     (spi_cs_n)
  );

  spi_fl_shift #(.DIV(DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_tx  (req_tx),
    .start_rx  (req_rx),
    .four      (req_four),
    .tx_be     (cfg_tx_be),
    .rx_be     (cfg_rx_be),
    .tx_word   (bus_wdata),
    .miso      (spi_miso),
    .start     (eng_start),
    .busy      (eng_busy),
    .done      (eng_done),
    .xfer_four (eng_four),
    .rx_mode   (eng_rxmode),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx_word   (rx_word)
  );
endmodule

// File: rtl/spi_fl_chk.sv
module spi_fl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       start,
  input logic       done,
  input logic       four,
  input logic       rx_mode,
  input logic       sclk,
  input logic       mosi,
  input logic [1:0] cs_n
);
  logic       sclk_d;
  logic [5:0] rises;
  logic       rise_now;

  assign rise_now = sclk && !sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_d <= sclk;
      if (start) rises <= '0;
      else if (rise_now) rises <= rises + 6'd1;
    end
  end

  assert_start_clears_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  assert_cs_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cs_n));

  assert_idle_clock_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  assert_mosi_steady_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  assert_rx_mosi_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_mode) |-> !mosi);

  assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rises + {5'd0, rise_now}) == (four ? 6'd32 : 6'd8)));
endmodule

bind spi_flash_ctl spi_fl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (eng_busy),
  .start   (eng_start),
  .done    (eng_done),
  .four    (eng_four),
  .rx_mode (eng_rxmode),
  .sclk    (spi_sclk),
  .mosi    (spi_mosi),
  .cs_n    (spi_cs_n)
);

// File: tb/spi_flash_ctl_tb.sv
module spi_flash_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 4;
  localparam int DIV = 4;
  localparam logic [AW-1:0] A_CFG = 4'h0;
  localparam logic [AW-1:0] A_CTL = 4'h8;
  localparam logic [AW-1:0] A_DAT = 4'hC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          spi_sclk, spi_mosi, spi_miso;
  logic [1:0]    spi_cs_n;

  int checks = 0;
  int fails  = 0;

  // flash model: serves slv_stream MSB first, one bit per rising edge
  logic [31:0] slv_stream = 32'h0;
  int          slv_base = 0;
  int          rise_total = 0;
  int          slv_idx;
  assign slv_idx  = rise_total - slv_base;
  assign spi_miso = (slv_idx >= 0 && slv_idx < 32) ? slv_stream[31 - slv_idx] : 1'b0;

  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_ctl #(.AW(AW), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: assembles serial bytes and compares them with the scoreboard
  logic       prev_sclk = 1'b0;
  logic [7:0] mbyte = 8'h0;
  int         mbits = 0;
  int         cyc = 0;
  int         last_rise = 0;
  always @(negedge clk) begin
    cyc++;
    if (spi_sclk && !prev_sclk) begin
      if (mbits != 0)
        check((cyc - last_rise) == DIV, "R11 sclk rise spacing", cyc - last_rise, DIV);
      last_rise = cyc;
      mbyte = {mbyte[6:0], spi_mosi};
      mbits++;
      rise_total++;
      if (mbits == 8) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10/R3 unexpected serial byte", {24'h0, mbyte}, 32'h0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mbyte == e, "R3/R4/R8 serial byte", {24'h0, mbyte}, {24'h0, e});
        end
        mbits = 0;
      end
    end
    prev_sclk = spi_sclk;
  end

  // bus tasks: called positioned just after a falling clock edge
  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    logic [31:0] v;
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      bus_read(A_CTL, v);
      if (v[27]) break;
      n++;
    end
  endtask

  task automatic set_slave(input logic [31:0] s);
    slv_stream = s;
    slv_base = rise_total;
  endtask

  task automatic push_word(input logic [31:0] w);
    exp_q.push_back(w[31:24]); exp_q.push_back(w[23:16]);
    exp_q.push_back(w[15:8]);  exp_q.push_back(w[7:0]);
  endtask

  function automatic logic [31:0] mk_ctl(input bit c0, input bit c1,
                                         input logic [1:0] len, input bit s);
    return {c0, c1, len, 1'b0, 2'b00, s, 24'h0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_CTL, v); check(v == 32'hC800_0000, "R1 ctl reset", v, 32'hC800_0000);
    bus_read(A_CFG, v); check(v == 32'h0, "R1 cfg reset", v, 32'h0);
    check(spi_cs_n == 2'b11, "R1 cs_n reset", {30'h0, spi_cs_n}, 32'h3);
    check(!spi_sclk, "R1 sclk idle", {31'h0, spi_sclk}, 32'h0);

    // R2 cs0 low with select on cs1: no receive starts
    bus_write(A_CFG, 32'h0800_0000);
    bus_write(A_CTL, mk_ctl(0, 1, 2'd0, 1));
    check(spi_cs_n == 2'b10, "R2 cs_n follows bits", {30'h0, spi_cs_n}, 32'h2);
    bus_read(A_CTL, v);
    check(v == (mk_ctl(0, 1, 2'd0, 1) | 32'h0800_0000), "R2/R9 ctl readback idle",
          v, mk_ctl(0, 1, 2'd0, 1) | 32'h0800_0000);

    // R3 one byte from bits 31:24, R5 busy window
    exp_q.push_back(8'hA5);
    bus_write(A_DAT, 32'hA512_3456);
    wait_busy(n); check(n == 8*DIV, "R5 busy cycles 1 byte", n, 8*DIV);

    // R3 length code 1 behaves as one byte
    bus_write(A_CTL, mk_ctl(0, 1, 2'd1, 1));
    exp_q.push_back(8'h3C);
    bus_write(A_DAT, 32'h3C00_00FF);
    wait_busy(n);

    // R4 4-byte big order
    bus_write(A_CTL, mk_ctl(0, 1, 2'd3, 1));
    push_word(32'h1122_3344);
    bus_write(A_DAT, 32'h1122_3344);
    wait_busy(n);
    // R4 4-byte little order, R5 busy window for 4 bytes
    bus_write(A_CFG, 32'h0);
    push_word(32'h4433_2211);
    bus_write(A_DAT, 32'h1122_3344);
    wait_busy(n); check(n == 32*DIV, "R5 busy cycles 4 bytes", n, 32*DIV);

    // R10 writes while busy are dropped
    bus_write(A_CTL, mk_ctl(0, 1, 2'd0, 1));
    exp_q.push_back(8'h5A);
    bus_write(A_DAT, 32'h5A00_0000);
    bus_write(A_CTL, mk_ctl(1, 0, 2'd3, 0));
    bus_write(A_DAT, 32'hFF00_0000);
    wait_busy(n);
    bus_read(A_CTL, v);
    check(v == (mk_ctl(0, 1, 2'd0, 1) | 32'h0800_0000), "R10 ctl unchanged",
          v, mk_ctl(0, 1, 2'd0, 1) | 32'h0800_0000);
    check(spi_cs_n == 2'b10, "R10 cs_n unchanged", {30'h0, spi_cs_n}, 32'h2);

    // R9 automatic receive when selected cs0 falls
    bus_write(A_CTL, mk_ctl(1, 1, 2'd3, 0));
    check(spi_cs_n == 2'b11, "R2 cs_n released", {30'h0, spi_cs_n}, 32'h3);
    bus_write(A_CFG, 32'h1000_0000);
    set_slave(32'hDEAD_BEEF);
    push_word(32'h0);
    bus_write(A_CTL, mk_ctl(0, 1, 2'd3, 0));
    bus_read(A_CTL, v); check(v[27] == 1'b0, "R9 auto receive started", v[27], 0);
    wait_busy(n);

    // R7 big order result; R8 read restarts a receive
    set_slave(32'h0102_0304);
    bus_write(A_CFG, 32'h0);
    push_word(32'h0);
    bus_read(A_DAT, v); check(v == 32'hDEAD_BEEF, "R7 rx big order", v, 32'hDEAD_BEEF);
    wait_busy(n); check(n == 32*DIV, "R8 read started receive", n, 32*DIV);

    // R7 little order result, next receive one byte
    bus_write(A_CTL, mk_ctl(0, 1, 2'd0, 0));
    set_slave(32'h9A00_0000);
    exp_q.push_back(8'h00);
    bus_read(A_DAT, v); check(v == 32'h0403_0201, "R7 rx little order", v, 32'h0403_0201);
    wait_busy(n);

    // R12 transmit leaves captured word alone
    set_slave(32'hFFFF_FFFF);
    exp_q.push_back(8'h77);
    bus_write(A_DAT, 32'h7700_0000);
    wait_busy(n);
    exp_q.push_back(8'h00);
    bus_read(A_DAT, v); check(v == 32'h9A00_0000, "R6/R12 rx byte in 31:24", v, 32'h9A00_0000);
    wait_busy(n);
    bus_read(A_DAT, v); check(v == 32'hFF00_0000, "R6 second rx byte", v, 32'hFF00_0000);
    exp_q.push_back(8'h00);
    wait_busy(n);

    bus_write(A_CTL, mk_ctl(1, 1, 2'd0, 0));
    check(spi_cs_n == 2'b11, "R2 cs_n final", {30'h0, spi_cs_n}, 32'h3);
    check(!spi_sclk, "R11 sclk low idle", {31'h0, spi_sclk}, 32'h0);
    check(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule